// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is a purely combinational 32-bit shifter for an integer datapath in which the shift distance is taken from a general register. It applies one of four shift kinds to a data word: logical left, logical right, arithmetic right or rotate right. It returns the shifted word together with a carry bit that follows register-specified shift rules. Only the least significant byte of the register value sets the distance, so distances from 0 to 255 are meaningful. Distances of 32 and beyond have their own result and carry rules.

The carry input is passed through whenever a shift leaves the carry unchanged. This lets the block sit directly between a flag register and its update mux. The block has no clock, no state and no handshake: its outputs follow its inputs within the same cycle. Immediate-form shifts and rotate-through-carry are handled elsewhere.

Top module: `barrel_shift_carry`

## Requirements
- R1: Only bits 7:0 of `amt_reg_i` set the shift distance; bits 31:8 have no effect on either output (a register value of 0x100 acts as a distance of 0).
- R2: With a distance of 0, `result_o` equals `opnd_i` and `carry_o` equals `carry_i`, whatever the value of `op_i`.
- R3: With `op_i` = 2'b00 (logical left) and a distance n from 1 to 31, `result_o` is `opnd_i` shifted left by n with zeros filled in, and `carry_o` is bit (32 - n) of `opnd_i`.
- R4: With logical left and a distance of exactly 32, `result_o` is 0 and `carry_o` is bit 0 of `opnd_i`. With a distance above 32, both outputs are 0.
- R5: With `op_i` = 2'b01 (logical right) and a distance n from 1 to 31, `result_o` is `opnd_i` shifted right by n with zeros filled in, and `carry_o` is bit (n - 1) of `opnd_i`.
- R6: With logical right and a distance of exactly 32, `result_o` is 0 and `carry_o` is bit 31 of `opnd_i`. With a distance above 32, both outputs are 0.
- R7: With `op_i` = 2'b10 (arithmetic right) and a distance n from 1 to 31, `result_o` is `opnd_i` shifted right by n with copies of bit 31 filled in, and `carry_o` is bit (n - 1) of `opnd_i`.
- R8: With arithmetic right and a distance of 32 or more, every bit of `result_o` equals bit 31 of `opnd_i`, and `carry_o` equals bit 31 of `opnd_i`.
- R9: With `op_i` = 2'b11 (rotate right), let m be the distance modulo 32. When m is not 0, `result_o` is `opnd_i` rotated right by m and `carry_o` is bit (m - 1) of `opnd_i`.
- R10: With rotate right, a nonzero distance and m equal to 0, `result_o` equals `opnd_i` and `carry_o` is bit 31 of `opnd_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Data word to be shifted |
| amt_reg_i | input | 32 | Register value whose low byte gives the shift distance |
| op_i | input | 2 | Shift kind: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| carry_i | input | 1 | Current carry flag, passed through when the carry is unchanged |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | New carry flag |

## Verification
The bound checker evaluates the output relations that hold for whole classes of distance on every input change. These are the pass-through at distance 0, the cleared outputs of logical shifts at and beyond 32, the sign flood of arithmetic shifts at 32 and above, and the preserved count of ones under rotation. The exact bit chosen as carry for each in-range distance, and the result for distances 1 to 31, are shown only by the bench. It compares every vector against its own behavioural model, using directed distances at 0, 1, 31, 32, 33, 63, 64 and 255, register values with bits set above the low byte, and a long pseudo-random sweep.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [1:0] {
    OP_LSL = 2'b00,
    OP_LSR = 2'b01,
    OP_ASR = 2'b10,
    OP_ROR = 2'b11
  } bsh_op_e;

  // Classification of the shift distance relative to the word width
  typedef struct packed {
    logic zero;   // distance is 0
    logic full;   // distance equals the word width
    logic over;   // distance exceeds the word width
    logic sat;    // distance is at least the word width
  } amt_class_t;

endpackage

// File: rtl/bsh_amt_decode.sv
module bsh_amt_decode
  import bsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [AMT_W-1:0]           amt_i,
  output amt_class_t                 cls_o,
  output logic [$clog2(DATA_W)-1:0]  k_o
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(DATA_W);

  always_comb begin
    cls_o.zero = (amt_i == '0);
    cls_o.full = (amt_i == WIDTH_AMT);
    cls_o.over = (amt_i > WIDTH_AMT);
    cls_o.sat  = cls_o.full | cls_o.over;
  end

  // Distance modulo the word width, used by every in-range shift and by rotate
  assign k_o = amt_i[SH_W-1:0];

endmodule

// File: rtl/bsh_core.sv
module bsh_core #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]          din,
  input  logic [$clog2(DATA_W)-1:0]  k,
  input  logic                       rotate,
  input  logic                       fill,
  output logic [DATA_W-1:0]          dout
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  // One right-shift stage per distance bit; vacated bits take either the
  // wrapped-around bits (rotate) or the fill value.
  generate
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int D = 1 << s;
      logic [DATA_W-1:0] moved;

      always_comb begin
        for (int b = 0; b < DATA_W; b++) begin
          if (b + D < DATA_W) moved[b] = stage[s][(b + D) % DATA_W];
          else                moved[b] = rotate ? stage[s][(b + D) % DATA_W] : fill;
        end
      end

      assign stage[s+1] = k[s] ? moved : stage[s];
    end
  endgenerate

  assign dout = stage[SH_W];

endmodule

// File: rtl/bsh_carry_pick.sv
module bsh_carry_pick #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]          src,
  input  logic [$clog2(DATA_W)-1:0]  k,
  output logic                       bit_o
);
  localparam int SH_W = $clog2(DATA_W);

  // Last bit moved past the low end; k = 0 wraps to the top bit, which is
  // the carry for a full-width shift and for a rotate by a multiple of the width.
  logic [SH_W-1:0] idx;
  assign idx   = k - SH_W'(1);
  assign bit_o = src[idx];

endmodule

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry
  import bsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [REG_W-1:0]  amt_reg_i,
  input  logic [1:0]        op_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int SH_W = $clog2(DATA_W);

  bsh_op_e            op;
  logic [AMT_W-1:0]   amt;
  amt_class_t         cls;
  logic [SH_W-1:0]    k;
  logic [DATA_W-1:0]  rev_in, core_in, core_out, rev_out, aligned;
  logic               sign, logical, edge_bit;

  assign op      = bsh_op_e'(op_i);
  assign amt     = amt_reg_i[AMT_W-1:0];
  assign sign    = opnd_i[DATA_W-1];
  assign logical = (op == OP_LSL) || (op == OP_LSR);

  bsh_amt_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .amt_i (amt),
    .cls_o (cls),
    .k_o   (k)
  );

  // Left shifts run through the right-shift network on a mirrored word
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
      assign rev_in[i]  = opnd_i[DATA_W-1-i];
      assign rev_out[i] = core_out[DATA_W-1-i];
    end
  endgenerate

  assign core_in = (op == OP_LSL) ? rev_in : opnd_i;

  bsh_core #(.DATA_W(DATA_W)) u_core (
    .din    (core_in),
    .k      (k),
    .rotate (op == OP_ROR),
    .fill   ((op == OP_ASR) && sign),
    .dout   (core_out)
  );

  assign aligned = (op == OP_LSL) ? rev_out : core_out;

  bsh_carry_pick #(.DATA_W(DATA_W)) u_pick (
    .src   (core_in),
    .k     (k),
    .bit_o (edge_bit)
  );

  always_comb begin
    if (cls.zero) begin
      result_o = opnd_i;
      carry_o  = carry_i;
    end else if (op == OP_ROR) begin
      result_o = aligned;
      carry_o  = edge_bit;
    end else if (cls.sat) begin
      if (op == OP_ASR) begin
        result_o = {DATA_W{sign}};
        carry_o  = sign;
      end else begin
        result_o = '0;
        carry_o  = logical && cls.full && edge_bit;
      end
    end else begin
      result_o = aligned;
      carry_o  = edge_bit;
    end
  end

endmodule

// File: rtl/bsh_check.sv
module bsh_check #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 32,
  parameter int AMT_W  = 8
) (
  input logic [DATA_W-1:0] opnd_i,
  input logic [REG_W-1:0]  amt_reg_i,
  input logic [1:0]        op_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o
);
  logic [AMT_W-1:0] n;
  logic             known;

  assign n     = amt_reg_i[AMT_W-1:0];
  assign known = !$isunknown({opnd_i, amt_reg_i, op_i, carry_i});

  always_comb begin
    if (known) begin
      if (n == '0) begin
        assert_zero_pass_R2: assert (result_o == opnd_i && carry_o == carry_i)
          else $error("zero distance altered outputs");
      end
      if (op_i == 2'b00 && n == AMT_W'(DATA_W)) begin
        assert_lsl_full_R4: assert (result_o == '0 && carry_o == opnd_i[0])
          else $error("left shift by width wrong");
      end
      if (op_i == 2'b01 && n == AMT_W'(DATA_W)) begin
        assert_lsr_full_R6: assert (result_o == '0 && carry_o == opnd_i[DATA_W-1])
          else $error("right shift by width wrong");
      end
      if (op_i[1] == 1'b0 && n > AMT_W'(DATA_W)) begin
        assert_logical_over_R4_R6: assert (result_o == '0 && carry_o == 1'b0)
          else $error("logical shift beyond width not cleared");
      end
      if (op_i == 2'b10 && n >= AMT_W'(DATA_W)) begin
        assert_asr_sat_R8: assert (result_o == {DATA_W{opnd_i[DATA_W-1]}}
                                   && carry_o == opnd_i[DATA_W-1])
          else $error("arithmetic shift saturation wrong");
      end
      if (op_i == 2'b11) begin
        assert_ror_ones_R9: assert ($countones(result_o) == $countones(opnd_i))
          else $error("rotate changed number of ones");
      end
      if (op_i == 2'b11 && n != '0 && n[$clog2(DATA_W)-1:0] == '0) begin
        assert_ror_wrap_R10: assert (result_o == opnd_i && carry_o == opnd_i[DATA_W-1])
          else $error("rotate by multiple of width wrong");
      end
    end
  end

endmodule

bind barrel_shift_carry bsh_check #(
  .DATA_W (DATA_W),
  .REG_W  (REG_W),
  .AMT_W  (AMT_W)
) u_chk (
  .opnd_i    (opnd_i),
  .amt_reg_i (amt_reg_i),
  .op_i      (op_i),
  .carry_i   (carry_i),
  .result_o  (result_o),
  .carry_o   (carry_o)
);

// File: tb/sim_barrel_shift_carry.sv
`timescale 1ns/1ps
module sim_barrel_shift_carry;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd, amt_reg, result;
  logic [1:0]  op;
  logic        cin, cout;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  barrel_shift_carry u0 (
    .opnd_i    (opnd),
    .amt_reg_i (amt_reg),
    .op_i      (op),
    .carry_i   (cin),
    .result_o  (result),
    .carry_o   (cout)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Behavioural model written from the requirements
  function automatic void model(input logic [31:0] x, input logic [31:0] r,
                                input logic [1:0] o, input logic ci,
                                output logic [31:0] y, output logic c,
                                output string tag);
    int n;
    int m;
    n = int'(r[7:0]);
    m = n % 32;
    if (n == 0) begin
      y = x; c = ci; tag = (r[31:8] != 0) ? "R1" : "R2";
      return;
    end
    case (o)
      2'b00: begin
        if (n < 32)       begin y = x << n; c = x[32-n]; tag = "R3"; end
        else if (n == 32) begin y = 0; c = x[0]; tag = "R4"; end
        else              begin y = 0; c = 1'b0; tag = "R4"; end
      end
      2'b01: begin
        if (n < 32)       begin y = x >> n; c = x[n-1]; tag = "R5"; end
        else if (n == 32) begin y = 0; c = x[31]; tag = "R6"; end
        else              begin y = 0; c = 1'b0; tag = "R6"; end
      end
      2'b10: begin
        if (n < 32) begin y = 32'($signed(x) >>> n); c = x[n-1]; tag = "R7"; end
        else        begin y = {32{x[31]}}; c = x[31]; tag = "R8"; end
      end
      default: begin
        if (m == 0) begin y = x; c = x[31]; tag = "R10"; end
        else begin y = (x >> m) | (x << (32 - m)); c = x[m-1]; tag = "R9"; end
      end
    endcase
    if (r[31:8] != 0) tag = {tag, "/R1"};
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] r,
                       input logic [1:0] o, input logic ci);
    logic [31:0] ey;
    logic        ec;
    string       tag;
    @(negedge clk);
    opnd = x; amt_reg = r; op = o; cin = ci;
    model(x, r, o, ci, ey, ec, tag);
    @(posedge clk);
    #1;
    checks++;
    if (result !== ey || cout !== ec) begin
      errors++;
      $display("FAIL %s: op=%0b x=%h amt=%h cin=%0b actual y=%h c=%0b expected y=%h c=%0b",
               tag, o, x, r, ci, result, cout, ey, ec);
    end
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [31:0] pats [4];
    int          dists [10];
    opnd = '0; amt_reg = '0; op = 2'b00; cin = 1'b0;
    pats[0] = 32'h8000_0001; pats[1] = 32'hDEAD_BEEF;
    pats[2] = 32'h7FFF_FFFE; pats[3] = 32'h0000_00F0;
    dists[0] = 0;  dists[1] = 1;  dists[2] = 2;  dists[3] = 17;
    dists[4] = 31; dists[5] = 32; dists[6] = 33; dists[7] = 63;
    dists[8] = 64; dists[9] = 255;

    // Reset phase: all-zero inputs give all-zero outputs (R2)
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (result !== 32'h0 || cout !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle: actual y=%h c=%0b expected y=00000000 c=0", result, cout);
    end
    rst = 1'b0;

    // Directed sweep over kinds, patterns, distances and carry-in (R2..R10)
    for (int o = 0; o < 4; o++)
      for (int p = 0; p < 4; p++)
        for (int d = 0; d < 10; d++)
          for (int ci = 0; ci < 2; ci++)
            apply(pats[p], 32'(dists[d]), 2'(o), 1'(ci));

    // Upper register bits must not matter (R1)
    for (int o = 0; o < 4; o++) begin
      apply(32'hC3C3_A5A5, 32'h0000_0100, 2'(o), 1'b1);
      apply(32'hC3C3_A5A5, 32'hFFFF_FF00, 2'(o), 1'b0);
      apply(32'hC3C3_A5A5, 32'h1234_5605, 2'(o), 1'b1);
      apply(32'hC3C3_A5A5, 32'hABCD_EF20, 2'(o), 1'b0);
    end

    // Pseudo-random vectors across all requirements
    lfsr = 32'h1F2E_3D4C;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] xv, rv;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      xv = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      rv = (i % 3 == 0) ? lfsr : {24'h0, lfsr[7:0]};
      apply(xv, rv, lfsr[9:8], lfsr[10]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule